// File: doc/BRIEF.md
# Paravirtual Queue Device Register Front End

This block is the register front end of a paravirtual PCI device with shared-memory queues, accessed by byte-addressed reads and writes on an I/O window. It holds the device feature word offered to the driver, the features the driver accepted, a queue selector, one page number per queue, a fixed queue size, a device status byte and an interrupt cause byte. Writes to the notify offset are turned into a one-cycle notify pulse for a queue that has been given memory. Offsets at and above the configuration start are passed through to a device-specific configuration port, rebased to zero.

The block signals the rest of the device through single-cycle pulses. One requests a device reset. One reports that the driver has just declared itself operational. One per queue reports a kick from the driver. Interrupt causes come in from the device core and are held until the driver reads the cause byte.

Top module: `vio_regfile`

## Requirements
- R1: A read of offset 0x00 returns the parameter HOST_FEAT ORed with bit 24 (notify when empty) and bit 30 (negotiation failure marker).
- R2: A write to offset 0x04 with bit 30 set stores the parameter MIN_FEAT as the accepted features, and offset 0x04 then reads back that value.
- R3: A write to offset 0x04 that asks for any bit outside HOST_FEAT|bit24 stores HOST_FEAT|bit24. Any other value is stored as written.
- R4: A write to offset 0x0E takes bits 15:0 and is ignored when that value is not below NQ. Offset 0x0E reads back the selector, and offset 0x0C reads back QSIZE.
- R5: A non-zero write to offset 0x08 stores the page number of the selected queue. Offset 0x08 reads back the page of the selected queue.
- R6: Writing zero to offset 0x08, or writing zero to the status byte at offset 0x12, raises reset_pulse for one cycle. It also clears the accepted features, the selector, the status byte, the interrupt byte, the interrupt line and every queue page.
- R7: A non-zero write to offset 0x12 stores the status byte. It raises ready_pulse for one cycle when bit 2 is set in the new value and was clear in the old one.
- R8: A write to offset 0x10 raises bit n of notify_pulse for one cycle, where n is bits 15:0 of the data. This happens only when n is below NQ and queue n has a non-zero page.
- R9: Pulsing irq_raise ORs irq_cause into the interrupt byte and raises irq when the cause is non-zero. A read of offset 0x13 returns the byte, then clears it and lowers irq.
- R10: A read of any offset below 0x14 that names no register returns 0xFFFFFFFF. Offset 0x10 is such an offset for reads.
- R11: Accesses at offsets 0x14 and above assert cfg_rd or cfg_wr in the same cycle, with cfg_off equal to the offset minus 0x14. A read returns cfg_rdata.
- R12: After rst_n, the accepted features, the selector, all pages, the status byte, the interrupt byte and irq read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte offset in the window |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq_raise | input | 1 | Device core adds interrupt causes |
| irq_cause | input | 8 | Cause bits to add |
| irq | output | 1 | Interrupt line |
| reset_pulse | output | 1 | Device reset request |
| ready_pulse | output | 1 | Driver became operational |
| notify_pulse | output | NQ | Per-queue kick |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_off | output | ADDR_W | Offset within configuration space |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data |

## Verification
Register state, pulses and read data all change at the clock edge that samples the strobe. The exceptions are the configuration strobes, which are combinational and valid in the strobe cycle. The bench drives each access on a falling edge. It checks configuration strobes half a cycle later, before the rising edge. It checks pulses, irq and read data at the falling edge after that rising edge, where each result is due one cycle after its stimulus. Each pulse is confirmed high in that one sample, and the following accesses show that no pulse fires where none is expected.

// File: rtl/vio_pkg.sv
`timescale 1ns/1ps
// Shared offsets and bit positions for the register front end.
// Assumes an 8-bit window offset; wider windows zero-extend these.
package vio_pkg;
    localparam logic [7:0] OFF_HOSTF  = 8'h00;
    localparam logic [7:0] OFF_GUESTF = 8'h04;
    localparam logic [7:0] OFF_QPAGE  = 8'h08;
    localparam logic [7:0] OFF_QSIZE  = 8'h0C;
    localparam logic [7:0] OFF_QSEL   = 8'h0E;
    localparam logic [7:0] OFF_NOTIFY = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h12;
    localparam logic [7:0] OFF_ISR    = 8'h13;
    localparam logic [7:0] OFF_CFG    = 8'h14;
    localparam int BIT_DRV_OK = 2;
    localparam int BIT_EMPTY  = 24;
    localparam int BIT_BADF   = 30;
endpackage

// File: rtl/vio_feat.sv
`timescale 1ns/1ps
// Accepted-feature register with fallback negotiation.
// Assumes MIN_FEAT is a subset of HOST_FEAT.
module vio_feat #(
    parameter logic [31:0] HOST_FEAT = 32'h0000_8025,
    parameter logic [31:0] MIN_FEAT  = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        wr_stb,
    input  logic [31:0] wdata,
    output logic [31:0] guest_feat
);
    import vio_pkg::*;
    localparam logic [31:0] OFFER = HOST_FEAT | (32'd1 << BIT_EMPTY);

    logic [31:0] next_feat;

    // Choose the value to store for a feature write.
    always_comb begin
        if (wdata[BIT_BADF])            next_feat = MIN_FEAT;
        else if ((wdata & ~OFFER) != 0) next_feat = OFFER;
        else                            next_feat = wdata;
    end

    // Hold the accepted features.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) guest_feat <= '0;
        else if (wr_stb)        guest_feat <= next_feat;
    end

    // R3: accepted features never leave the offered set.
    a_r3_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (guest_feat & ~OFFER) == 32'd0);
    // R2: a write carrying the failure marker lands on the minimal set.
    a_r2_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !soft_rst && wdata[BIT_BADF]) |=> guest_feat == MIN_FEAT);
endmodule

// File: rtl/vio_queues.sv
`timescale 1ns/1ps
// Queue selector, per-queue page numbers and notify gating.
// Assumes the descriptor base is the page number shifted by PAGE_SHIFT.
module vio_queues #(
    parameter int NQ         = 3,
    parameter int PAGE_SHIFT = 12,
    localparam int SEL_W     = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          sel_wr,
    input  logic          page_wr,
    input  logic          notify_wr,
    input  logic [31:0]   wdata,
    output logic [15:0]   sel,
    output logic [31:0]   sel_page,
    output logic [NQ-1:0] notify_pulse
);
    localparam int BASE_W = 32 + PAGE_SHIFT;

    logic [31:0]     page [NQ];
    logic [NQ-1:0]   live;
    logic [SEL_W-1:0] sel_i;

    assign sel_i    = sel[SEL_W-1:0];
    assign sel_page = page[sel_i];

    // Update the selector only with an in-range queue index.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) sel <= '0;
        else if (sel_wr && wdata[15:0] < 16'(NQ)) sel <= wdata[15:0];
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [BASE_W-1:0] desc_base;
        assign desc_base = {page[q], {PAGE_SHIFT{1'b0}}};
        assign live[q]   = desc_base != '0;

        // Store this queue's page when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) page[q] <= '0;
            else if (page_wr && sel_i == SEL_W'(q)) page[q] <= wdata;
        end

        // Kick this queue when the index matches and it has memory.
        always_ff @(posedge clk) begin
            if (!rst_n) notify_pulse[q] <= 1'b0;
            else notify_pulse[q] <= notify_wr && wdata[15:0] == 16'(q) && live[q];
        end
    end

    // R8: at most one queue is kicked per cycle.
    a_r8_one_kick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(notify_pulse));
    // R4: the selector stays within the queue count.
    a_r4_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel < 16'(NQ));
endmodule

// File: rtl/vio_isr.sv
`timescale 1ns/1ps
// Interrupt cause byte and line; a read clears both.
// Assumes a raise in the same cycle as a clearing read survives the read.
module vio_isr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       raise,
    input  logic [7:0] cause,
    input  logic       rd_clr,
    output logic [7:0] isr,
    output logic       irq
);
    // Accumulate causes and clear on read or device reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            isr <= '0;
            irq <= 1'b0;
        end else if (rd_clr) begin
            isr <= raise ? cause : 8'd0;
            irq <= raise && cause != 0;
        end else if (raise && cause != 0) begin
            isr <= isr | cause;
            irq <= 1'b1;
        end
    end

    // R9: a read with no new cause leaves the byte and line clear.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !raise) |=> (isr == 8'd0 && !irq));
    // R9: the line is only high with a cause pending.
    a_r9_line_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> isr != 8'd0);
endmodule

// File: rtl/vio_regfile.sv
`timescale 1ns/1ps
// Register front end: decodes the window, holds status, muxes reads,
// forwards configuration accesses and issues reset and ready pulses.
// Assumes one access per cycle and read data consumed one cycle later.
module vio_regfile #(
    parameter int          NQ        = 3,
    parameter int          ADDR_W    = 8,
    parameter int          QSIZE     = 256,
    parameter logic [31:0] HOST_FEAT = 32'h0000_8025,
    parameter logic [31:0] MIN_FEAT  = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    input  logic              irq_raise,
    input  logic [7:0]        irq_cause,
    output logic              irq,
    output logic              reset_pulse,
    output logic              ready_pulse,
    output logic [NQ-1:0]     notify_pulse,
    output logic              cfg_rd,
    output logic              cfg_wr,
    output logic [ADDR_W-1:0] cfg_off,
    output logic [31:0]       cfg_wdata,
    input  logic [31:0]       cfg_rdata
);
    import vio_pkg::*;
    localparam logic [31:0] HOST_READ = HOST_FEAT | (32'd1 << BIT_EMPTY) | (32'd1 << BIT_BADF);

    logic        hit_gf, hit_pg, hit_sel, hit_ntf, hit_st, hit_isr, in_cfg;
    logic        soft_rst;
    logic [7:0]  status, isr;
    logic [31:0] guest_feat, sel_page;
    logic [15:0] sel;

    // Decode the offset into register hits.
    always_comb begin
        hit_gf  = addr == ADDR_W'(OFF_GUESTF);
        hit_pg  = addr == ADDR_W'(OFF_QPAGE);
        hit_sel = addr == ADDR_W'(OFF_QSEL);
        hit_ntf = addr == ADDR_W'(OFF_NOTIFY);
        hit_st  = addr == ADDR_W'(OFF_STATUS);
        hit_isr = addr == ADDR_W'(OFF_ISR);
        in_cfg  = addr >= ADDR_W'(OFF_CFG);
    end

    assign soft_rst  = wr_en && ((hit_st && wdata[7:0] == 8'd0) || (hit_pg && wdata == 32'd0));
    assign cfg_rd    = rd_en && in_cfg;
    assign cfg_wr    = wr_en && in_cfg;
    assign cfg_off   = addr - ADDR_W'(OFF_CFG);
    assign cfg_wdata = wdata;

    vio_feat #(.HOST_FEAT(HOST_FEAT), .MIN_FEAT(MIN_FEAT)) u_feat (
        .clk, .rst_n, .soft_rst,
        .wr_stb(wr_en && hit_gf), .wdata, .guest_feat
    );

    vio_queues #(.NQ(NQ)) u_q (
        .clk, .rst_n, .soft_rst,
        .sel_wr(wr_en && hit_sel), .page_wr(wr_en && hit_pg),
        .notify_wr(wr_en && hit_ntf), .wdata,
        .sel, .sel_page, .notify_pulse
    );

    vio_isr u_isr (
        .clk, .rst_n, .soft_rst,
        .raise(irq_raise), .cause(irq_cause),
        .rd_clr(rd_en && hit_isr), .isr, .irq
    );

    // Hold the status byte; zero is a reset rather than a store.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) status <= '0;
        else if (wr_en && hit_st) status <= wdata[7:0];
    end

    // Issue reset and ready pulses one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_pulse <= 1'b0;
            ready_pulse <= 1'b0;
        end else begin
            reset_pulse <= soft_rst;
            ready_pulse <= wr_en && hit_st && wdata[7:0] != 8'd0
                           && wdata[BIT_DRV_OK] && !status[BIT_DRV_OK];
        end
    end

    // Register the read data for the addressed offset.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            if (in_cfg)                              rd_data <= cfg_rdata;
            else if (addr == ADDR_W'(OFF_HOSTF))     rd_data <= HOST_READ;
            else if (hit_gf)                         rd_data <= guest_feat;
            else if (hit_pg)                         rd_data <= sel_page;
            else if (addr == ADDR_W'(OFF_QSIZE))     rd_data <= 32'(QSIZE);
            else if (hit_sel)                        rd_data <= {16'd0, sel};
            else if (hit_st)                         rd_data <= {24'd0, status};
            else if (hit_isr)                        rd_data <= {24'd0, isr};
            else                                     rd_data <= '1;
        end
    end

    // R7: a ready pulse only follows a status holding the operational bit.
    a_r7_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pulse |-> status[BIT_DRV_OK]);
    // R6: a reset pulse coincides with cleared status and features.
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (status == 8'd0 && guest_feat == 32'd0 && sel == 16'd0));
    // R11: configuration strobes never fire below the configuration start.
    a_r11_cfg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd || cfg_wr) |-> addr >= ADDR_W'(OFF_CFG));
endmodule

// File: tb/sim_vio_regfile.sv
`timescale 1ns/1ps
module sim_vio_regfile;
    localparam int NQ = 3;
    localparam int QSIZE = 256;
    localparam logic [31:0] HOST_FEAT = 32'h0000_8025;
    localparam logic [31:0] MIN_FEAT  = 32'h0000_0001;
    localparam logic [31:0] OFFER = HOST_FEAT | (32'd1 << 24);
    localparam logic [31:0] HREAD = OFFER | (32'd1 << 30);

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq_raise = 0;
    logic [7:0] addr = 0, irq_cause = 0;
    logic [31:0] wdata = 0, rd_data, cfg_wdata, cfg_rdata;
    logic irq, reset_pulse, ready_pulse, cfg_rd, cfg_wr;
    logic [NQ-1:0] notify_pulse;
    logic [7:0] cfg_off;

    int n_chk = 0, n_bad = 0;
    logic p_rst, p_rdy;
    logic [NQ-1:0] p_ntf;
    logic [31:0] rv;

    always #10 clk = ~clk;
    assign cfg_rdata = {24'hA5A5A5, cfg_off};

    vio_regfile #(.NQ(NQ), .QSIZE(QSIZE), .HOST_FEAT(HOST_FEAT), .MIN_FEAT(MIN_FEAT)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(posedge clk);
        @(negedge clk); wr_en = 0;
        p_rst = reset_pulse; p_rdy = ready_pulse; p_ntf = notify_pulse;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1;
        @(posedge clk);
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        rd(8'h04, rv); chk("R12 features", rv, 0);
        rd(8'h0E, rv); chk("R12 selector", rv, 0);
        rd(8'h08, rv); chk("R12 page", rv, 0);
        rd(8'h12, rv); chk("R12 status", rv, 0);
        rd(8'h13, rv); chk("R12 isr", rv, 0);
        chk("R12 irq", irq, 0);
        // R1 host word, R4 size
        rd(8'h00, rv); chk("R1 host read", rv, HREAD);
        rd(8'h0C, rv); chk("R4 size", rv, QSIZE);
        // R2/R3 single-bit sweep
        for (int b = 0; b < 32; b++) begin
            logic [31:0] w, e;
            w = 32'd1 << b;
            if (b == 30) e = MIN_FEAT;
            else if (OFFER[b]) e = w;
            else e = OFFER;
            wr(8'h04, w);
            rd(8'h04, rv);
            chk(b == 30 ? "R2 fallback" : "R3 negotiate", rv, e);
        end
        wr(8'h04, OFFER); rd(8'h04, rv); chk("R3 full offer kept", rv, OFFER);
        // R4 selector sweep
        begin
            logic [15:0] exp_sel;
            exp_sel = 0;
            for (int v = 0; v < 6; v++) begin
                wr(8'h0E, v);
                if (v < NQ) exp_sel = 16'(v);
                rd(8'h0E, rv); chk("R4 select", rv, {16'd0, exp_sel});
            end
            wr(8'h0E, 32'h0001_0001); rd(8'h0E, rv); chk("R4 low half", rv, 1);
        end
        // R8 no kicks before pages
        for (int i = 0; i < NQ; i++) begin
            wr(8'h10, i); chk("R8 unset queue", p_ntf, 0);
        end
        // R5 pages
        for (int q = 0; q < NQ; q++) begin
            wr(8'h0E, q); wr(8'h08, 32'h100 + q);
            chk("R5 no reset on nonzero", p_rst, 0);
        end
        for (int q = 0; q < NQ; q++) begin
            wr(8'h0E, q); rd(8'h08, rv); chk("R5 page", rv, 32'h100 + q);
        end
        // R8 kick sweep
        for (int i = 0; i < 5; i++) begin
            wr(8'h10, i);
            chk("R8 kick", p_ntf, (i < NQ) ? (NQ'(1) << i) : '0);
        end
        wr(8'h10, 32'h0001_0000); chk("R8 low half index", p_ntf, 1);
        // R7 ready edge
        wr(8'h12, 32'h04); chk("R7 rise", p_rdy, 1);
        rd(8'h12, rv); chk("R7 stored", rv, 4);
        wr(8'h12, 32'h05); chk("R7 held", p_rdy, 0);
        wr(8'h12, 32'h01); chk("R7 clear", p_rdy, 0);
        wr(8'h12, 32'h07); chk("R7 rise again", p_rdy, 1);
        // R9 interrupt
        @(negedge clk); irq_raise = 1; irq_cause = 8'h01;
        @(negedge clk); irq_cause = 8'h02;
        @(negedge clk); irq_raise = 0; irq_cause = 0;
        chk("R9 irq high", irq, 1);
        rd(8'h13, rv); chk("R9 isr read", rv, 3);
        chk("R9 irq low", irq, 0);
        rd(8'h13, rv); chk("R9 isr cleared", rv, 0);
        // R10 unmapped
        for (int a = 0; a < 8'h14; a++) begin
            if (!(a inside {0, 4, 8, 8'h0C, 8'h0E, 8'h12, 8'h13})) begin
                rd(8'(a), rv); chk("R10 unmapped", rv, 32'hFFFF_FFFF);
            end
        end
        // R11 config forwarding
        for (int a = 8'h14; a < 8'h20; a++) begin
            rd(8'(a), rv); chk("R11 cfg read", rv, {24'hA5A5A5, 8'(a - 8'h14)});
        end
        @(negedge clk); addr = 8'h1A; wdata = 32'hDEAD_0001; wr_en = 1;
        #5;
        chk("R11 cfg_wr", cfg_wr, 1);
        chk("R11 cfg_off", cfg_off, 8'h06);
        chk("R11 cfg_wdata", cfg_wdata, 32'hDEAD_0001);
        @(negedge clk); wr_en = 0;
        // R6 status zero reset
        wr(8'h0E, 2); wr(8'h04, 32'h1);
        @(negedge clk); irq_raise = 1; irq_cause = 8'h04;
        @(negedge clk); irq_raise = 0; irq_cause = 0;
        wr(8'h12, 0); chk("R6 status pulse", p_rst, 1);
        chk("R6 irq cleared", irq, 0);
        rd(8'h04, rv); chk("R6 features", rv, 0);
        rd(8'h0E, rv); chk("R6 selector", rv, 0);
        rd(8'h12, rv); chk("R6 status", rv, 0);
        rd(8'h13, rv); chk("R6 isr", rv, 0);
        rd(8'h08, rv); chk("R6 page q0", rv, 0);
        wr(8'h10, 1); chk("R6 no kick after reset", p_ntf, 0);
        // R6 page zero reset
        wr(8'h0E, 1); wr(8'h08, 32'h55); wr(8'h12, 32'h04);
        wr(8'h08, 0); chk("R6 page-zero pulse", p_rst, 1);
        rd(8'h12, rv); chk("R6 status after page reset", rv, 0);
        rd(8'h0E, rv); chk("R6 selector after page reset", rv, 0);
        wr(8'h0E, 1); rd(8'h08, rv); chk("R6 page cleared", rv, 0);
        wr(8'h10, 1); chk("R8 cleared queue no kick", p_ntf, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule